// File: doc/BRIEF.md
# Buck Gate Drive Sequencer

This block turns a digital PWM request into the two gate enables of a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It guarantees that the two are never on together, and it inserts a fixed dead interval of both-off cycles at every hand-over between them. Two comparator flags come in as plain digital inputs. A low-current flag selects non-synchronous operation, in which the low side stays off during the off-time. A low-bootstrap flag requests a short low-side pulse that recharges the high-side driver's bootstrap capacitor. This pulse also cuts into a request that is held at full duty.

The controller is one state machine with seven states. `ST_OFF` is idle, or the non-synchronous off-time, with both switches off. `ST_DT_HS` is the dead interval before the high side turns on. `ST_HS` has the high side conducting. `ST_DT_LS` is the dead interval before the low side turns on. `ST_LS` is the synchronous off-time with the low side on. `ST_DT_RF` is the dead interval before a refresh pulse. `ST_RFSH` is the refresh pulse itself. The transitions are:
- OFF→DT_RF on a refresh request, otherwise OFF→DT_HS while the request is high.
- DT_HS→HS once the dead count expires.
- HS→DT_RF on a refresh request. Otherwise, when the request falls, HS→DT_LS in synchronous mode or HS→OFF in non-synchronous mode.
- DT_LS→LS once the dead count expires.
- LS→RFSH on a refresh request, because the low side is already on. Otherwise LS→DT_HS when the request rises.
- DT_RF→RFSH once the dead count expires.
- RFSH ends after the pulse count. It goes to DT_HS if the request is high, to LS in synchronous mode, and to OFF otherwise.

A refresh request that arrives during a dead interval is held until the machine reaches a state that accepts it. The operating mode is latched only on a rising edge of the PWM request.

Top module: `buck_gate_seq`

## Requirements
- R1: `hs_en` and `ls_en` are never high in the same cycle.
- R2: When the PWM request rises while the high side is off, both enables stay low for DEAD_CYC (default 5) cycles. `hs_en` then rises on the DEAD_CYC+1-th clock edge after the request is first sampled high.
- R3: In synchronous mode, `hs_en` falls on the first edge after the request falls. `ls_en` rises DEAD_CYC cycles later and stays high while the request stays low. This includes the return to the off-time after a refresh pulse.
- R4: The mode is latched on each rising edge of the PWM request. `cur_low`=1 selects non-synchronous mode and `cur_low`=0 selects synchronous mode. A change of `cur_low` at any other time has no effect until the next rising edge.
- R5: In non-synchronous mode, `ls_en` stays low for the whole off-time unless a refresh pulse is in progress.
- R6: A rising edge of `boot_low` turns `hs_en` off on the next edge. After DEAD_CYC both-off cycles, `ls_en` is high for exactly REFRESH_CYC (default 16) cycles. If the low side is already on, the pulse starts at once and `ls_en` stays high.
- R7: After a refresh pulse in non-synchronous mode with the request low, `ls_en` goes low and stays low.
- R8: After a refresh pulse with the request still high, both enables are low for DEAD_CYC cycles and then `hs_en` resumes. Each new rising edge of `boot_low` repeats the sequence.
- R9: `boot_low` held high produces exactly one pulse. No further pulse occurs until it has gone low and risen again.
- R10: While `rst_n` is low at a clock edge, both enables go low, the machine returns to `ST_OFF`, and the mode is cleared to non-synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (dead and pulse counts are in its cycles) |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_req | input | 1 | PWM request from the modulator, high = high side wanted |
| boot_low | input | 1 | Bootstrap-voltage-low comparator flag |
| cur_low | input | 1 | Charge-current-below-threshold comparator flag |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |

## Verification
The assertions assume that the flags are already synchronous to `clk` and that PWM periods are long compared with the dead interval. A request edge that falls inside a dead interval is simply taken up in the next stable state. The stimulus changes every input only at falling clock edges. It holds each PWM phase for at least DEAD_CYC+1 cycles, except where a short hold is the point of a check. It raises `boot_low` both while the high side conducts and during the synchronous off-time. One sequence keeps `boot_low` high across many cycles to probe re-arming.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_DT_HS = 3'd1,
        ST_HS    = 3'd2,
        ST_DT_LS = 3'd3,
        ST_LS    = 3'd4,
        ST_DT_RF = 3'd5,
        ST_RFSH  = 3'd6
    } seq_state_e;
endpackage

// File: rtl/bgs_mode_latch.sv
module bgs_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic cur_low,
    output logic sync_mode
);
    logic pwm_q;
    logic pwm_rise;

    assign pwm_rise = pwm_req && !pwm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q     <= 1'b0;
            sync_mode <= 1'b0;
        end else begin
            pwm_q <= pwm_req;
            if (pwm_rise)
                sync_mode <= !cur_low;
        end
    end

    // R4: mode only moves on a request rising edge
    a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_rise |=> $stable(sync_mode));
endmodule

// File: rtl/bgs_refresh_arm.sv
module bgs_refresh_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_low,
    input  logic take,
    output logic req
);
    logic boot_q;
    logic pend;
    logic boot_rise;

    assign boot_rise = boot_low && !boot_q;
    assign req       = pend || boot_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            boot_q <= boot_low;
            pend   <= req && !take;
        end
    end

    // R9: a request only appears on a fresh flag edge or while one is pending
    a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take) && boot_low && $past(boot_low)) |-> !req);
endmodule

// File: rtl/bgs_phase_timer.sv
module bgs_phase_timer #(
    parameter int MAX_CYC = 16,
    localparam int CW = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(MAX_CYC);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (restart)
            count <= '0;
        else if (count != TOP)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import bgs_pkg::*;
#(
    parameter int DEAD_CYC    = 5,
    parameter int REFRESH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic boot_low,
    input  logic cur_low,
    output logic hs_en,
    output logic ls_en
);
    localparam int MAX_CYC = (DEAD_CYC > REFRESH_CYC) ? DEAD_CYC : REFRESH_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] RF_LAST   = CW'(REFRESH_CYC - 1);

    seq_state_e    state, state_nxt;
    logic          sync_mode;
    logic          rf_req;
    logic          rf_take;
    logic [CW-1:0] tmr;
    logic          dead_done;
    logic          rf_done;
    logic          accepting;

    bgs_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_req   (pwm_req),
        .cur_low   (cur_low),
        .sync_mode (sync_mode)
    );

    bgs_refresh_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_low (boot_low),
        .take     (rf_take),
        .req      (rf_req)
    );

    bgs_phase_timer #(.MAX_CYC(MAX_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_nxt != state),
        .count   (tmr)
    );

    assign dead_done = (tmr == DEAD_LAST);
    assign rf_done   = (tmr == RF_LAST);
    assign accepting = (state == ST_OFF) || (state == ST_HS) || (state == ST_LS);
    assign rf_take   = rf_req && accepting;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:   if (rf_req)          state_nxt = ST_DT_RF;
                      else if (pwm_req)    state_nxt = ST_DT_HS;
            ST_DT_HS: if (dead_done)       state_nxt = ST_HS;
            ST_HS:    if (rf_req)          state_nxt = ST_DT_RF;
                      else if (!pwm_req)   state_nxt = sync_mode ? ST_DT_LS : ST_OFF;
            ST_DT_LS: if (dead_done)       state_nxt = ST_LS;
            ST_LS:    if (rf_req)          state_nxt = ST_RFSH;
                      else if (pwm_req)    state_nxt = ST_DT_HS;
            ST_DT_RF: if (dead_done)       state_nxt = ST_RFSH;
            ST_RFSH:  if (rf_done)
                          state_nxt = pwm_req   ? ST_DT_HS :
                                      sync_mode ? ST_LS : ST_OFF;
            default:                       state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= (state_nxt == ST_HS);
            ls_en <= (state_nxt == ST_LS) || (state_nxt == ST_RFSH);
        end
    end

    // R1: never both switches on
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R2: high-side entry always follows a full dead count
    a_r2_dead_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(tmr) == DEAD_LAST && !$past(ls_en)));

    // R5: without synchronous mode the low side is on only for a refresh
    a_r5_nonsync_ls: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en && !sync_mode) |-> (state == ST_RFSH));

    // R6: a refresh pulse lasts exactly the programmed count
    a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RFSH && $past(state) == ST_RFSH) |-> ($past(tmr) == RF_LAST));

    // R8: high side never turns on straight out of a refresh pulse
    a_r8_dead_after_rf: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RFSH) |-> !hs_en);
endmodule

// File: tb/buck_gate_seq_test.sv
`timescale 1ns/1ps
module buck_gate_seq_test;
    localparam int CLK_PERIOD = 5;
    localparam int NVEC = 28;

    // {pwm, boot, cur, wait[7:0], exp_hs, exp_ls, tag[3:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {3'b100, 8'd5,  2'b00, 4'd2},
        {3'b100, 8'd1,  2'b10, 4'd2},
        {3'b000, 8'd1,  2'b00, 4'd3},
        {3'b000, 8'd4,  2'b00, 4'd3},
        {3'b000, 8'd1,  2'b01, 4'd3},
        {3'b001, 8'd10, 2'b01, 4'd4},
        {3'b101, 8'd1,  2'b00, 4'd2},
        {3'b101, 8'd5,  2'b10, 4'd2},
        {3'b100, 8'd3,  2'b10, 4'd4},
        {3'b000, 8'd1,  2'b00, 4'd5},
        {3'b000, 8'd20, 2'b00, 4'd4},
        {3'b101, 8'd6,  2'b10, 4'd2},
        {3'b111, 8'd1,  2'b00, 4'd6},
        {3'b111, 8'd5,  2'b01, 4'd6},
        {3'b111, 8'd15, 2'b01, 4'd6},
        {3'b111, 8'd1,  2'b00, 4'd8},
        {3'b111, 8'd5,  2'b10, 4'd8},
        {3'b111, 8'd40, 2'b10, 4'd9},
        {3'b101, 8'd3,  2'b10, 4'd9},
        {3'b111, 8'd6,  2'b01, 4'd8},
        {3'b001, 8'd15, 2'b01, 4'd6},
        {3'b001, 8'd1,  2'b00, 4'd7},
        {3'b001, 8'd20, 2'b00, 4'd7},
        {3'b100, 8'd6,  2'b10, 4'd2},
        {3'b000, 8'd6,  2'b01, 4'd3},
        {3'b010, 8'd1,  2'b01, 4'd6},
        {3'b010, 8'd16, 2'b01, 4'd3},
        {3'b100, 8'd1,  2'b00, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0;
    logic boot_low = 1'b0;
    logic cur_low = 1'b0;
    logic hs_en, ls_en;

    int checks = 0;
    int fails = 0;
    int overlap = 0;
    bit done = 1'b0;

    buck_gate_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_req  (pwm_req),
        .boot_low (boot_low),
        .cur_low  (cur_low),
        .hs_en    (hs_en),
        .ls_en    (ls_en)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    // R1 monitor: counts cycles with both enables high
    always @(negedge clk)
        if (rst_n && hs_en && ls_en) overlap++;

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic hs_exp, input logic ls_exp);
        checks++;
        if (hs_en !== hs_exp || ls_en !== ls_exp) begin
            fails++;
            $display("FAIL %s: hs_en=%b ls_en=%b expected hs_en=%b ls_en=%b at %0t",
                     req, hs_en, ls_en, hs_exp, ls_exp, $time);
        end
    endtask

    task automatic finish_run();
        checks++;
        if (overlap != 0) begin
            fails++;
            $display("FAIL R1: overlap cycles=%0d expected 0", overlap);
        end
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", 1'b0, 1'b0);   // R10 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            {pwm_req, boot_low, cur_low} = VEC[i][16:14];
            repeat (int'(VEC[i][13:6])) @(posedge clk);
            @(negedge clk);
            check(tag_name(VEC[i][3:0]), VEC[i][5], VEC[i][4]);
        end

        // R10: reset while high side conducts
        pwm_req = 1'b1; cur_low = 1'b0; boot_low = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check("R2", 1'b1, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (6) @(posedge clk); @(negedge clk);
        check("R10", 1'b1, 1'b0);

        // R10: mode after reset is non-synchronous until a fresh request edge
        pwm_req = 1'b0; cur_low = 1'b1;
        repeat (2) @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        pwm_req = 1'b1;
        repeat (6) @(posedge clk); @(negedge clk);
        check("R10", 1'b1, 1'b0);
        pwm_req = 1'b0;
        repeat (12) @(posedge clk); @(negedge clk);
        check("R5", 1'b0, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule